// File: doc/BRIEF.md
# Instruction-Driven Nibble Port Unit

This block sits beside a small 4-bit core and carries out the core's port commands on four 4-bit ports. Each cycle the core may present one command: read a port into memory, write a value to a port, set or clear the bits chosen by a mask, test whether all masked bits are 1 or all are 0 (the result tells the core to skip its next instruction), or load the direction latch of the per-pin port. Reads and tests return their data and skip flag one cycle later.

The four ports are a push-pull output port, an open-drain output port, a bidirectional port that has no direction register, and a bidirectional port with a separate direction bit for each pin. The bidirectional port without a direction register becomes an input after any read-type command and an output after any write-type command. Reset and a backup (low-power retention) input put every pin into a defined safe state. In backup mode the pin latches keep their contents and the bidirectional inputs are switched off.

Top module: `port_unit`

## Requirements
- R1: A read-type command (IN=1, TSTT=5, TSTF=6 on `cmdOp`) to the auto-direction port (number 4) puts that port into input mode (`adOe`=0), and the command returns the pin levels.
- R2: A write-type command (OUT=2, SETB=3, CLRB=4) to the auto-direction port puts it into output mode (`adOe`=1) and drives its output latch on `adOut`.
- R3: While `rstN` is low, the push-pull port (number 2) drives low (`ppOe`=1, `ppOut`=0), both bidirectional ports are inputs, and `respValid` is 0. After reset all latches and direction bits are cleared.
- R4: While `backupMode` is 1, `ppOe`, `adOe`, `pdOe` and `odDrive` are all 0, and pins that are inputs read as 0. Latches and directions are kept and drive the pins again once backup ends.
- R5: DIR (7) loads `cmdData` into the per-pin direction latch of port 5 whatever `portSel` holds (bit i = 1 makes pin i an output). A read of port 5 returns the latch bit for output pins and the pin level for input pins.
- R6: SETB ORs the mask in `cmdData` into the addressed port's latch, and CLRB clears the masked bits. All other bits keep their values.
- R7: OUT replaces the addressed port's latch with `cmdData`. A read of an output-only port returns its latch.
- R8: TSTT sets `skip` when every masked bit of the read value is 1. TSTF sets `skip` when every masked bit is 0. A zero mask always skips.
- R9: A command addressed to a port number other than 2 to 5 changes no latch and no pin. If it is a read-type command, it returns `rdData`=0 and `skip`=0.
- R10: `respValid` is 1 for exactly the one cycle after a read-type command, and 0 after every other command. IN returns `skip`=0.
- R11: The open-drain port (number 3) pulls pin i low (`odDrive[i]`=1) when latch bit i is 1, and releases every pin during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| backupMode | input | 1 | Retention mode: pins released, inputs disabled |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | Command code: NOP 0, IN 1, OUT 2, SETB 3, CLRB 4, TSTT 5, TSTF 6, DIR 7 |
| portSel | input | 4 | Port number addressed |
| cmdData | input | 4 | Write value, bit mask or direction bits |
| adPadIn | input | 4 | Pin levels of the auto-direction port |
| pdPadIn | input | 4 | Pin levels of the per-pin-direction port |
| respValid | output | 1 | Read-type result present |
| rdData | output | 4 | Value read |
| skip | output | 1 | Test result: skip the next instruction |
| ppOut | output | 4 | Push-pull port output value |
| ppOe | output | 1 | Push-pull port output enable |
| odDrive | output | 4 | Open-drain pull-down enables |
| adOut | output | 4 | Auto-direction port output value |
| adOe | output | 1 | Auto-direction port output enable |
| pdOut | output | 4 | Per-pin port output values |
| pdOe | output | 4 | Per-pin port output enables |

## Verification
Latches, direction state and the auto-direction mode update on the clock edge that samples the command, so the pin outputs show the change one edge later. The read response (`respValid`, `rdData`, `skip`) is registered at that same edge. The pin gating from `rstN` and `backupMode` is combinational and needs no edge. The bench drives every command on a falling edge, removes it at the next falling edge, and samples all results at that moment, exactly one rising edge after the command was sampled. Reset and backup checks are taken while the level is held.

// File: rtl/port_unit_pkg.sv
package port_unit_pkg;

  localparam int DW    = 4;
  localparam int NPORT = 4;

  // slot index of each port inside the datapath arrays
  localparam int IDX_PP = 0;
  localparam int IDX_OD = 1;
  localparam int IDX_AD = 2;
  localparam int IDX_PD = 3;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_IN   = 3'd1,
    OP_OUT  = 3'd2,
    OP_SETB = 3'd3,
    OP_CLRB = 3'd4,
    OP_TSTT = 3'd5,
    OP_TSTF = 3'd6,
    OP_DIR  = 3'd7
  } portOp_e;

  typedef enum logic [1:0] {
    WR_LOAD = 2'd0,
    WR_SET  = 2'd1,
    WR_CLR  = 2'd2
  } wrKind_e;

  typedef struct packed {
    logic [NPORT-1:0] wrHit;
    logic [NPORT-1:0] rdHit;
    wrKind_e          wrKind;
    logic             dirLoad;
    logic             rdReq;
    logic             tstTrue;
    logic             tstFalse;
    logic [DW-1:0]    arg;
  } portStrobe_t;

endpackage

// File: rtl/port_unit_ctrl.sv
module port_unit_ctrl
  import port_unit_pkg::*;
#(
  parameter logic [3:0] PP_NUM = 4'd2,
  parameter logic [3:0] OD_NUM = 4'd3,
  parameter logic [3:0] AD_NUM = 4'd4,
  parameter logic [3:0] PD_NUM = 4'd5
) (
  input  logic          cmdValid,
  input  logic [2:0]    cmdOp,
  input  logic [3:0]    portSel,
  input  logic [DW-1:0] cmdData,
  output portStrobe_t   strobe
);

  localparam logic [3:0] PNUM [NPORT] = '{PP_NUM, OD_NUM, AD_NUM, PD_NUM};

  portOp_e          op;
  logic [NPORT-1:0] selVec;
  logic             isRead;
  logic             isWrite;

  assign op = portOp_e'(cmdOp);

  for (genvar g = 0; g < NPORT; g++) begin : g_sel
    assign selVec[g] = (portSel == PNUM[g]);
  end

  always_comb begin
    isRead  = (op == OP_IN) || (op == OP_TSTT) || (op == OP_TSTF);
    isWrite = (op == OP_OUT) || (op == OP_SETB) || (op == OP_CLRB);
  end

  always_comb begin
    strobe          = '0;
    strobe.arg      = cmdData;
    strobe.rdReq    = cmdValid && isRead;
    strobe.rdHit    = (cmdValid && isRead) ? selVec : '0;
    strobe.wrHit    = (cmdValid && isWrite) ? selVec : '0;
    strobe.dirLoad  = cmdValid && (op == OP_DIR);
    strobe.tstTrue  = cmdValid && (op == OP_TSTT);
    strobe.tstFalse = cmdValid && (op == OP_TSTF);
    case (op)
      OP_SETB: strobe.wrKind = WR_SET;
      OP_CLRB: strobe.wrKind = WR_CLR;
      default: strobe.wrKind = WR_LOAD;
    endcase
  end

endmodule

// File: rtl/port_unit_dp.sv
module port_unit_dp
  import port_unit_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          backupMode,
  input  portStrobe_t   strobe,
  input  logic [DW-1:0] adPadIn,
  input  logic [DW-1:0] pdPadIn,
  output logic          respValid,
  output logic [DW-1:0] rdData,
  output logic          skip,
  output logic [DW-1:0] ppOut,
  output logic          ppOe,
  output logic [DW-1:0] odDrive,
  output logic [DW-1:0] adOut,
  output logic          adOe,
  output logic [DW-1:0] pdOut,
  output logic [DW-1:0] pdOe
);

  logic [DW-1:0] outLatch [NPORT];
  logic [DW-1:0] rdVal    [NPORT];
  logic          adOutMode;
  logic [DW-1:0] pdDir;
  logic [DW-1:0] inEn;
  logic          pinsLive;
  logic [DW-1:0] readMux;
  logic          anyHit;
  logic          testPass;

  function automatic logic [DW-1:0] applyWrite(
    input wrKind_e kind, input logic [DW-1:0] old, input logic [DW-1:0] arg);
    case (kind)
      WR_LOAD: applyWrite = arg;
      WR_SET:  applyWrite = old | arg;
      WR_CLR:  applyWrite = old & ~arg;
      default: applyWrite = old;
    endcase
  endfunction

  // output latches, one per port
  for (genvar g = 0; g < NPORT; g++) begin : g_latch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        outLatch[g] <= '0;
      else if (strobe.wrHit[g])
        outLatch[g] <= applyWrite(strobe.wrKind, outLatch[g], strobe.arg);
    end
  end

  // auto-direction mode: last access kind wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      adOutMode <= 1'b0;
    else if (strobe.wrHit[IDX_AD])
      adOutMode <= 1'b1;
    else if (strobe.rdHit[IDX_AD])
      adOutMode <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pdDir <= '0;
    else if (strobe.dirLoad)
      pdDir <= strobe.arg;
  end

  assign inEn     = {DW{~backupMode}};
  assign pinsLive = rstN && !backupMode;

  always_comb begin
    rdVal[IDX_PP] = outLatch[IDX_PP];
    rdVal[IDX_OD] = outLatch[IDX_OD];
    rdVal[IDX_AD] = adPadIn & inEn;
    rdVal[IDX_PD] = (pdDir & outLatch[IDX_PD]) | (~pdDir & pdPadIn & inEn);
  end

  always_comb begin
    readMux = '0;
    for (int i = 0; i < NPORT; i++)
      if (strobe.rdHit[i]) readMux = readMux | rdVal[i];
    anyHit = |strobe.rdHit;
    if (strobe.tstTrue)
      testPass = anyHit && ((readMux & strobe.arg) == strobe.arg);
    else if (strobe.tstFalse)
      testPass = anyHit && ((readMux & strobe.arg) == '0);
    else
      testPass = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      rdData    <= '0;
      skip      <= 1'b0;
    end else begin
      respValid <= strobe.rdReq;
      rdData    <= strobe.rdReq ? readMux : '0;
      skip      <= testPass;
    end
  end

  // pin gating by reset and backup
  always_comb begin
    ppOut   = rstN ? outLatch[IDX_PP] : '0;
    ppOe    = rstN ? !backupMode : 1'b1;
    odDrive = pinsLive ? outLatch[IDX_OD] : '0;
    adOut   = outLatch[IDX_AD];
    adOe    = pinsLive && adOutMode;
    pdOut   = outLatch[IDX_PD];
    pdOe    = pinsLive ? pdDir : '0;
  end

endmodule

// File: rtl/port_unit.sv
module port_unit
  import port_unit_pkg::*;
#(
  parameter logic [3:0] PP_NUM = 4'd2,
  parameter logic [3:0] OD_NUM = 4'd3,
  parameter logic [3:0] AD_NUM = 4'd4,
  parameter logic [3:0] PD_NUM = 4'd5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       backupMode,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic [3:0] portSel,
  input  logic [3:0] cmdData,
  input  logic [3:0] adPadIn,
  input  logic [3:0] pdPadIn,
  output logic       respValid,
  output logic [3:0] rdData,
  output logic       skip,
  output logic [3:0] ppOut,
  output logic       ppOe,
  output logic [3:0] odDrive,
  output logic [3:0] adOut,
  output logic       adOe,
  output logic [3:0] pdOut,
  output logic [3:0] pdOe
);

  portStrobe_t strobe;

  port_unit_ctrl #(
    .PP_NUM(PP_NUM), .OD_NUM(OD_NUM), .AD_NUM(AD_NUM), .PD_NUM(PD_NUM)
  ) ctrl_i (
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .portSel  (portSel),
    .cmdData  (cmdData),
    .strobe   (strobe)
  );

  port_unit_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .backupMode (backupMode),
    .strobe     (strobe),
    .adPadIn    (adPadIn),
    .pdPadIn    (pdPadIn),
    .respValid  (respValid),
    .rdData     (rdData),
    .skip       (skip),
    .ppOut      (ppOut),
    .ppOe       (ppOe),
    .odDrive    (odDrive),
    .adOut      (adOut),
    .adOe       (adOe),
    .pdOut      (pdOut),
    .pdOe       (pdOe)
  );

endmodule

// File: rtl/port_unit_chk.sv
module port_unit_chk #(
  parameter logic [3:0] PP_NUM = 4'd2,
  parameter logic [3:0] OD_NUM = 4'd3,
  parameter logic [3:0] AD_NUM = 4'd4,
  parameter logic [3:0] PD_NUM = 4'd5
) (
  input logic       clk,
  input logic       rstN,
  input logic       backupMode,
  input logic       cmdValid,
  input logic [2:0] cmdOp,
  input logic [3:0] portSel,
  input logic [3:0] cmdData,
  input logic       respValid,
  input logic [3:0] rdData,
  input logic       skip,
  input logic [3:0] ppOut,
  input logic       ppOe,
  input logic [3:0] odDrive,
  input logic       adOe,
  input logic [3:0] pdOe
);

  logic rdOp, wrOp, unimpl;
  assign rdOp   = (cmdOp == 3'd1) || (cmdOp == 3'd5) || (cmdOp == 3'd6);
  assign wrOp   = (cmdOp == 3'd2) || (cmdOp == 3'd3) || (cmdOp == 3'd4);
  assign unimpl = (portSel != PP_NUM) && (portSel != OD_NUM) &&
                  (portSel != AD_NUM) && (portSel != PD_NUM);

  always @(posedge clk) begin
    if (!rstN)
      AST_RESET_SAFE: assert (ppOe && ppOut == 4'd0 && odDrive == 4'd0 &&
                              !adOe && pdOe == 4'd0 && !respValid); // R3
    if (rstN && backupMode)
      AST_BACKUP_RELEASE: assert (!ppOe && !adOe && pdOe == 4'd0 &&
                                  odDrive == 4'd0); // R4
  end

  AST_AD_READ_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && rdOp && portSel == AD_NUM |=> !adOe); // R1

  AST_AD_WRITE_OUTPUT: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && wrOp && portSel == AD_NUM && !backupMode ##1 !backupMode |-> adOe); // R2

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOp == 3'd7 && !backupMode ##1 !backupMode |-> pdOe == $past(cmdData)); // R5

  AST_SET_PP: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOp == 3'd3 && portSel == PP_NUM |=> ppOut == ($past(ppOut) | $past(cmdData))); // R6

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> respValid == $past(cmdValid && rdOp)); // R10

  AST_UNIMPL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && rdOp && unimpl |=> !skip && rdData == 4'd0); // R9

endmodule

bind port_unit port_unit_chk #(
  .PP_NUM(PP_NUM), .OD_NUM(OD_NUM), .AD_NUM(AD_NUM), .PD_NUM(PD_NUM)
) chk_i (
  .clk(clk), .rstN(rstN), .backupMode(backupMode), .cmdValid(cmdValid),
  .cmdOp(cmdOp), .portSel(portSel), .cmdData(cmdData), .respValid(respValid),
  .rdData(rdData), .skip(skip), .ppOut(ppOut), .ppOe(ppOe), .odDrive(odDrive),
  .adOe(adOe), .pdOe(pdOe)
);

// File: tb/port_unit_tb_top.sv
module port_unit_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       backupMode = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [3:0] portSel = 4'd0;
  logic [3:0] cmdData = 4'd0;
  logic [3:0] adPadIn = 4'd0;
  logic [3:0] pdPadIn = 4'd0;
  logic       respValid, skip, ppOe, adOe;
  logic [3:0] rdData, ppOut, odDrive, adOut, pdOut, pdOe;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  port_unit dut_i (
    .clk(clk), .rstN(rstN), .backupMode(backupMode), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .portSel(portSel), .cmdData(cmdData), .adPadIn(adPadIn),
    .pdPadIn(pdPadIn), .respValid(respValid), .rdData(rdData), .skip(skip),
    .ppOut(ppOut), .ppOe(ppOe), .odDrive(odDrive), .adOut(adOut), .adOe(adOe),
    .pdOut(pdOut), .pdOe(pdOe)
  );

  typedef struct packed {
    logic [2:0] op;
    logic [3:0] port;
    logic [3:0] arg;
    logic [3:0] adPad;
    logic [3:0] pdPad;
    logic       eV;
    logic [3:0] eD;
    logic       eS;
    logic [3:0] ePp;
    logic       eAdOe;
    logic [3:0] ePdOe;
    logic [3:0] eOd;
  } vec_t;

  // op codes: IN 1 OUT 2 SETB 3 CLRB 4 TSTT 5 TSTF 6 DIR 7; ports PP 2 OD 3 AD 4 PD 5
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{3'd2, 4'd2, 4'hA, 4'h0, 4'h0, 1'b0, 4'h0, 1'b0, 4'hA, 1'b0, 4'h0, 4'h0},
    '{3'd3, 4'd2, 4'h5, 4'h0, 4'h0, 1'b0, 4'h0, 1'b0, 4'hF, 1'b0, 4'h0, 4'h0},
    '{3'd4, 4'd2, 4'h3, 4'h0, 4'h0, 1'b0, 4'h0, 1'b0, 4'hC, 1'b0, 4'h0, 4'h0},
    '{3'd1, 4'd2, 4'h0, 4'h0, 4'h0, 1'b1, 4'hC, 1'b0, 4'hC, 1'b0, 4'h0, 4'h0},
    '{3'd5, 4'd2, 4'hC, 4'h0, 4'h0, 1'b1, 4'hC, 1'b1, 4'hC, 1'b0, 4'h0, 4'h0},
    '{3'd5, 4'd2, 4'h6, 4'h0, 4'h0, 1'b1, 4'hC, 1'b0, 4'hC, 1'b0, 4'h0, 4'h0},
    '{3'd6, 4'd2, 4'h3, 4'h0, 4'h0, 1'b1, 4'hC, 1'b1, 4'hC, 1'b0, 4'h0, 4'h0},
    '{3'd6, 4'd2, 4'h0, 4'h0, 4'h0, 1'b1, 4'hC, 1'b1, 4'hC, 1'b0, 4'h0, 4'h0},
    '{3'd2, 4'd4, 4'h9, 4'h0, 4'h0, 1'b0, 4'h0, 1'b0, 4'hC, 1'b1, 4'h0, 4'h0},
    '{3'd1, 4'd4, 4'h0, 4'h6, 4'h0, 1'b1, 4'h6, 1'b0, 4'hC, 1'b0, 4'h0, 4'h0},
    '{3'd3, 4'd4, 4'h2, 4'h0, 4'h0, 1'b0, 4'h0, 1'b0, 4'hC, 1'b1, 4'h0, 4'h0},
    '{3'd6, 4'd4, 4'h9, 4'h6, 4'h0, 1'b1, 4'h6, 1'b1, 4'hC, 1'b0, 4'h0, 4'h0},
    '{3'd7, 4'hF, 4'h5, 4'h0, 4'h0, 1'b0, 4'h0, 1'b0, 4'hC, 1'b0, 4'h5, 4'h0},
    '{3'd2, 4'd5, 4'h3, 4'h0, 4'h0, 1'b0, 4'h0, 1'b0, 4'hC, 1'b0, 4'h5, 4'h0},
    '{3'd1, 4'd5, 4'h0, 4'h0, 4'hC, 1'b1, 4'h9, 1'b0, 4'hC, 1'b0, 4'h5, 4'h0},
    '{3'd2, 4'd9, 4'hF, 4'h0, 4'h0, 1'b0, 4'h0, 1'b0, 4'hC, 1'b0, 4'h5, 4'h0},
    '{3'd1, 4'd9, 4'h0, 4'hF, 4'hF, 1'b1, 4'h0, 1'b0, 4'hC, 1'b0, 4'h5, 4'h0},
    '{3'd6, 4'd9, 4'h0, 4'h0, 4'h0, 1'b1, 4'h0, 1'b0, 4'hC, 1'b0, 4'h5, 4'h0},
    '{3'd2, 4'd3, 4'h6, 4'h0, 4'h0, 1'b0, 4'h0, 1'b0, 4'hC, 1'b0, 4'h5, 4'h6}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // drive on a falling edge, sample at the next falling edge (one rising edge later)
  task automatic runCmd(input logic [2:0] op, input logic [3:0] port, input logic [3:0] arg,
                        input logic [3:0] adPad, input logic [3:0] pdPad);
    cmdValid = 1'b1;
    cmdOp    = op;
    portSel  = port;
    cmdData  = arg;
    adPadIn  = adPad;
    pdPadIn  = pdPad;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdOp    = 3'd0;
  endtask

  initial begin
    #(4 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R3: state while reset is held
    chk("R3 reset ppOe", {7'd0, ppOe}, 8'd1);
    chk("R3 reset ppOut", {4'd0, ppOut}, 8'd0);
    chk("R3 reset adOe/pdOe", {3'd0, adOe, pdOe}, 8'd0);
    chk("R11 reset odDrive", {4'd0, odDrive}, 8'd0);
    chk("R3 reset respValid", {7'd0, respValid}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);

    // table: R1 R2 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      runCmd(VECS[i].op, VECS[i].port, VECS[i].arg, VECS[i].adPad, VECS[i].pdPad);
      chk($sformatf("R10 vec%0d respValid", i), {7'd0, respValid}, {7'd0, VECS[i].eV});
      chk($sformatf("R7/R1/R5/R9 vec%0d rdData", i), {4'd0, rdData}, {4'd0, VECS[i].eD});
      chk($sformatf("R8 vec%0d skip", i), {7'd0, skip}, {7'd0, VECS[i].eS});
      chk($sformatf("R6 vec%0d ppOut", i), {4'd0, ppOut}, {4'd0, VECS[i].ePp});
      chk($sformatf("R1/R2 vec%0d adOe", i), {7'd0, adOe}, {7'd0, VECS[i].eAdOe});
      chk($sformatf("R5 vec%0d pdOe", i), {4'd0, pdOe}, {4'd0, VECS[i].ePdOe});
      chk($sformatf("R11 vec%0d odDrive", i), {4'd0, odDrive}, {4'd0, VECS[i].eOd});
    end

    // R5: per-pin port output values
    chk("R5 pdOut latch", {4'd0, pdOut}, 8'h03);
    // R2: auto port drives its latch
    runCmd(3'd2, 4'd4, 4'h4, 4'h0, 4'h0);
    chk("R2 adOe after OUT", {7'd0, adOe}, 8'd1);
    chk("R2 adOut value", {4'd0, adOut}, 8'h04);
    // R10: pulse lasts one cycle only
    runCmd(3'd1, 4'd2, 4'h0, 4'h0, 4'h0);
    @(negedge clk);
    chk("R10 respValid drops", {7'd0, respValid}, 8'd0);

    // R4: backup mode
    backupMode = 1'b1;
    #1;
    chk("R4 backup ppOe", {7'd0, ppOe}, 8'd0);
    chk("R4 backup adOe/pdOe", {3'd0, adOe, pdOe}, 8'd0);
    chk("R4 backup odDrive", {4'd0, odDrive}, 8'd0);
    @(negedge clk);
    runCmd(3'd1, 4'd4, 4'h0, 4'hF, 4'hF);
    chk("R4 backup auto read", {4'd0, rdData}, 8'h00);
    runCmd(3'd1, 4'd5, 4'h0, 4'hF, 4'hF);
    chk("R4 backup per-pin read", {4'd0, rdData}, 8'h01);
    backupMode = 1'b0;
    #1;
    chk("R4 exit ppOe/ppOut", {3'd0, ppOe, ppOut}, 8'h1C);
    chk("R4 exit pdOe", {4'd0, pdOe}, 8'h05);
    chk("R4 exit odDrive", {4'd0, odDrive}, 8'h06);
    chk("R1 auto port input after backup read", {7'd0, adOe}, 8'd0);

    // R3/R11: mid-run reset
    @(negedge clk);
    runCmd(3'd2, 4'd4, 4'h7, 4'h0, 4'h0);
    rstN = 1'b0;
    #1;
    chk("R3 mid reset ppOut low", {3'd0, ppOe, ppOut}, 8'h10);
    chk("R11 mid reset od released", {4'd0, odDrive}, 8'h00);
    chk("R3 mid reset auto input", {7'd0, adOe}, 8'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R3 after reset pdOe cleared", {4'd0, pdOe}, 8'h00);
    runCmd(3'd1, 4'd2, 4'h0, 4'h0, 4'h0);
    chk("R3 after reset latch cleared", {4'd0, rdData}, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule